// File: doc/BRIEF.md
# Single-Level Context Shadow Registers

This block keeps one saved copy of three core registers: the 5-bit status flags, the 8-bit working register and the 4-bit bank select register. The core strobes it when it vectors to an interrupt of either priority, or when it runs a fast call. In that cycle the block copies the live register values into its shadow. When the core later runs a return marked fast, the block presents the saved values on its restore outputs for one cycle and raises a restore-valid strobe. The core loads its registers from those outputs.

Only one layer is stored. Any capture replaces what is held. If a high-priority interrupt arrives while a low-priority handler is still running, the low-priority context is lost. A clobber output pulses whenever a capture lands on a context that no fast return has consumed yet. The shadow has no software read or write path. Its only outputs are the restore bundle and the two strobes.

Top module: `ctx_shadow_regs`

## Requirements
- R1: After reset, `rst_valid` and `ctx_clobber` are 0 and all three restore outputs are 0. A fast return issued with no prior capture restores zeros.
- R2: A low-priority vector strobe (`vec_lo`) in cycle N captures the three live values into the shadow.
- R3: A high-priority vector strobe (`vec_hi`) in cycle N captures the three live values into the shadow.
- R4: A fast call strobe (`call_fast`) in cycle N captures the three live values into the shadow.
- R5: A fast return is a cycle with both `ret_strobe` and `ret_fast` high. A fast return in cycle N makes `rst_valid` high in cycle N+1 only. In that cycle the restore outputs carry the shadow contents as they stood in cycle N.
- R6: A restore does not clear the shadow. A second fast return with no capture in between restores the same values.
- R7: A cycle with `ret_strobe` high and `ret_fast` low (a normal return), or with `ret_fast` high alone, gives no restore strobe. The restore outputs keep their previous values.
- R8: A second capture before a fast return overwrites the first. The next fast return restores the newest context.
- R9: `ctx_clobber` pulses for one cycle, in cycle N+1, when a capture in cycle N meets a context that is still unconsumed. It stays low for a capture that follows a fast return, and for the first capture after reset.
- R10: When a capture and a fast return fall in the same cycle, the restore delivers the older context and the shadow takes the new one. `ctx_clobber` stays low.
- R11: In cycles without a capture strobe, changes on the live register inputs do not alter the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_stat | input | 5 | Current status flags |
| live_wreg | input | 8 | Current working register |
| live_bank | input | 4 | Current bank select |
| vec_lo | input | 1 | Core vectors to a low-priority interrupt this cycle |
| vec_hi | input | 1 | Core vectors to a high-priority interrupt this cycle |
| call_fast | input | 1 | Core executes a fast call this cycle |
| ret_strobe | input | 1 | Core executes a return this cycle |
| ret_fast | input | 1 | The return in this cycle is a fast return |
| rst_stat | output | 5 | Status value to restore |
| rst_wreg | output | 8 | Working register value to restore |
| rst_bank | output | 4 | Bank select value to restore |
| rst_valid | output | 1 | One-cycle restore strobe |
| ctx_clobber | output | 1 | One-cycle pulse: a capture overwrote an unconsumed context |

## Verification
A corrupted shadow stays hidden until the next fast return. One cycle after that return, the wrong value appears on the restore outputs. The bench therefore follows every capture scenario with a fast return and compares all three fields. A wrong pending bit shows up one cycle after the next capture, as a missing or spurious clobber pulse. A bad restore strobe shows up in the very cycle after a return. Same-cycle capture and restore is exercised on its own, because an ordering error there moves values between the old and new contexts.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;
    localparam int STAT_W = 5;
    localparam int WREG_W = 8;
    localparam int BANK_W = 4;
    localparam int CTX_W  = STAT_W + WREG_W + BANK_W;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [WREG_W-1:0] wreg;
        logic [BANK_W-1:0] bank;
    } ctx_t;

    typedef struct packed {
        logic capture;
        logic restore;
    } ctx_evt_t;
endpackage

// File: rtl/ctx_evt_decode.sv
module ctx_evt_decode
    import ctx_shadow_pkg::*;
(
    input  logic     vec_lo,
    input  logic     vec_hi,
    input  logic     call_fast,
    input  logic     ret_strobe,
    input  logic     ret_fast,
    output ctx_evt_t evt
);
    always_comb begin
        evt.capture = vec_lo | vec_hi | call_fast;
        evt.restore = ret_strobe & ret_fast;
    end
endmodule

// File: rtl/ctx_shadow_store.sv
module ctx_shadow_store
    import ctx_shadow_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctx_evt_t evt,
    input  ctx_t     live,
    output ctx_t     shadow,
    output ctx_t     rest_data,
    output logic     rest_valid
);
    typedef struct packed {
        ctx_t shadow;
        ctx_t rest;
        logic valid;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = evt.restore;
        if (evt.restore) begin
            st_d.rest = st_q.shadow;
        end
        if (evt.capture) begin
            st_d.shadow = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow     = st_q.shadow;
    assign rest_data  = st_q.rest;
    assign rest_valid = st_q.valid;
endmodule

// File: rtl/ctx_pending_track.sv
module ctx_pending_track
    import ctx_shadow_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctx_evt_t evt,
    output logic     clobber
);
    typedef struct packed {
        logic pending;
        logic clobber;
    } trk_t;

    trk_t tr_d, tr_q;

    always_comb begin
        tr_d         = tr_q;
        tr_d.clobber = evt.capture & tr_q.pending & ~evt.restore;
        if (evt.capture) begin
            tr_d.pending = 1'b1;
        end else if (evt.restore) begin
            tr_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    assign clobber = tr_q.clobber;
endmodule

// File: rtl/ctx_shadow_regs.sv
module ctx_shadow_regs
    import ctx_shadow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] live_stat,
    input  logic [WREG_W-1:0] live_wreg,
    input  logic [BANK_W-1:0] live_bank,
    input  logic              vec_lo,
    input  logic              vec_hi,
    input  logic              call_fast,
    input  logic              ret_strobe,
    input  logic              ret_fast,
    output logic [STAT_W-1:0] rst_stat,
    output logic [WREG_W-1:0] rst_wreg,
    output logic [BANK_W-1:0] rst_bank,
    output logic              rst_valid,
    output logic              ctx_clobber
);
    ctx_evt_t evt;
    ctx_t     live;
    ctx_t     shadow;
    ctx_t     rest_data;

    assign live.stat = live_stat;
    assign live.wreg = live_wreg;
    assign live.bank = live_bank;

    ctx_evt_decode u_dec (
        .vec_lo     (vec_lo),
        .vec_hi     (vec_hi),
        .call_fast  (call_fast),
        .ret_strobe (ret_strobe),
        .ret_fast   (ret_fast),
        .evt        (evt)
    );

    ctx_shadow_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .live       (live),
        .shadow     (shadow),
        .rest_data  (rest_data),
        .rest_valid (rst_valid)
    );

    ctx_pending_track u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .clobber (ctx_clobber)
    );

    assign rst_stat = rest_data.stat;
    assign rst_wreg = rest_data.wreg;
    assign rst_bank = rest_data.bank;
endmodule

// File: rtl/ctx_shadow_chk.sv
module ctx_shadow_chk
    import ctx_shadow_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic vec_lo,
    input logic vec_hi,
    input logic call_fast,
    input logic ret_strobe,
    input logic ret_fast,
    input ctx_t live,
    input ctx_t shadow,
    input ctx_t rest_data,
    input logic rst_valid,
    input logic ctx_clobber
);
    p_capture_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_lo |=> shadow == $past(live));
    p_capture_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_hi |=> shadow == $past(live));
    p_capture_call_r4: assert property (@(posedge clk) disable iff (!rst_n)
        call_fast |=> shadow == $past(live));
    p_restore_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && ret_fast) |=> rst_valid && rest_data == $past(shadow));
    p_shadow_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && ret_fast && !vec_lo && !vec_hi && !call_fast) |=> $stable(shadow));
    p_no_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_strobe && ret_fast) |=> !rst_valid && $stable(rest_data));
    p_clobber_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clobber |-> $past(vec_lo || vec_hi || call_fast));
    p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && ret_fast) |=> !ctx_clobber);
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_lo || vec_hi || call_fast) |=> $stable(shadow));
endmodule

bind ctx_shadow_regs ctx_shadow_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vec_lo      (vec_lo),
    .vec_hi      (vec_hi),
    .call_fast   (call_fast),
    .ret_strobe  (ret_strobe),
    .ret_fast    (ret_fast),
    .live        (live),
    .shadow      (shadow),
    .rest_data   (rest_data),
    .rst_valid   (rst_valid),
    .ctx_clobber (ctx_clobber)
);

// File: tb/ctx_shadow_regs_tb.sv
module ctx_shadow_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] live_stat = '0;
    logic [7:0] live_wreg = '0;
    logic [3:0] live_bank = '0;
    logic       vec_lo = 0, vec_hi = 0, call_fast = 0, ret_strobe = 0, ret_fast = 0;
    logic [4:0] rst_stat;
    logic [7:0] rst_wreg;
    logic [3:0] rst_bank;
    logic       rst_valid, ctx_clobber;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_shadow_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .live_stat(live_stat), .live_wreg(live_wreg), .live_bank(live_bank),
        .vec_lo(vec_lo), .vec_hi(vec_hi), .call_fast(call_fast),
        .ret_strobe(ret_strobe), .ret_fast(ret_fast),
        .rst_stat(rst_stat), .rst_wreg(rst_wreg), .rst_bank(rst_bank),
        .rst_valid(rst_valid), .ctx_clobber(ctx_clobber)
    );

    // One clock: drive at the falling edge, sample 1 time unit after the rising edge.
    task automatic cyc(input bit lo, input bit hi, input bit call, input bit rs, input bit rf,
                       input logic [4:0] s, input logic [7:0] w, input logic [3:0] b);
        @(negedge clk);
        vec_lo = lo; vec_hi = hi; call_fast = call; ret_strobe = rs; ret_fast = rf;
        live_stat = s; live_wreg = w; live_bank = b;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, live_stat, live_wreg, live_bank);
    endtask

    task automatic check_out(input string req, input bit ev,
                             input logic [4:0] es, input logic [7:0] ew, input logic [3:0] eb);
        checks++;
        if (rst_valid !== ev || rst_stat !== es || rst_wreg !== ew || rst_bank !== eb) begin
            fails++;
            $display("FAIL %s: got valid=%0b stat=%h wreg=%h bank=%h, expected valid=%0b stat=%h wreg=%h bank=%h",
                     req, rst_valid, rst_stat, rst_wreg, rst_bank, ev, es, ew, eb);
        end
    endtask

    task automatic check_clob(input string req, input bit exp);
        checks++;
        if (ctx_clobber !== exp) begin
            fails++;
            $display("FAIL %s: clobber got %0b expected %0b", req, ctx_clobber, exp);
        end
    endtask

    task automatic t_reset();   // R1
        check_out("R1", 0, '0, '0, '0);
        check_clob("R1", 0);
        cyc(0, 0, 0, 1, 1, 5'h1f, 8'hff, 4'hf);
        check_out("R1", 1, '0, '0, '0);
    endtask

    task automatic t_capture_lo();   // R2, R9 first capture
        cyc(1, 0, 0, 0, 0, 5'h15, 8'h3c, 4'h9);
        check_clob("R9", 0);
        cyc(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0);
        check_out("R2", 1, 5'h15, 8'h3c, 4'h9);
    endtask

    task automatic t_capture_hi();   // R3, R9 after a consumed context
        cyc(0, 1, 0, 0, 0, 5'h0a, 8'ha5, 4'h6);
        check_clob("R9", 0);
        cyc(0, 0, 0, 1, 1, 5'h1f, 8'h11, 4'h2);
        check_out("R3", 1, 5'h0a, 8'ha5, 4'h6);
    endtask

    task automatic t_fast_call();   // R4, R5
        cyc(0, 0, 1, 0, 0, 5'h13, 8'h7e, 4'hc);
        cyc(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0);
        check_out("R4", 1, 5'h13, 8'h7e, 4'hc);
        idle();
        check_out("R5", 0, 5'h13, 8'h7e, 4'hc);
    endtask

    task automatic t_repeat();   // R6
        cyc(0, 0, 0, 1, 1, 5'h01, 8'h02, 4'h3);
        check_out("R6", 1, 5'h13, 8'h7e, 4'hc);
    endtask

    task automatic t_plain_ret();   // R7
        cyc(0, 0, 1, 0, 0, 5'h04, 8'h44, 4'h1);
        cyc(0, 0, 0, 1, 0, 5'h00, 8'h00, 4'h0);
        check_out("R7", 0, 5'h13, 8'h7e, 4'hc);
        cyc(0, 0, 0, 0, 1, 5'h00, 8'h00, 4'h0);
        check_out("R7", 0, 5'h13, 8'h7e, 4'hc);
        cyc(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0);
        check_out("R7", 1, 5'h04, 8'h44, 4'h1);
    endtask

    task automatic t_nested();   // R8, R9
        cyc(1, 0, 0, 0, 0, 5'h11, 8'h22, 4'h3);
        check_clob("R9", 0);
        cyc(0, 1, 0, 0, 0, 5'h0e, 8'hdd, 4'hb);
        check_clob("R9", 1);
        idle();
        check_clob("R9", 0);
        cyc(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0);
        check_out("R8", 1, 5'h0e, 8'hdd, 4'hb);
    endtask

    task automatic t_same_cycle();   // R10
        cyc(0, 0, 1, 0, 0, 5'h19, 8'h5a, 4'h7);
        cyc(0, 1, 0, 1, 1, 5'h06, 8'hc3, 4'he);
        check_out("R10", 1, 5'h19, 8'h5a, 4'h7);
        check_clob("R10", 0);
        cyc(0, 0, 0, 1, 1, 5'h00, 8'h00, 4'h0);
        check_out("R10", 1, 5'h06, 8'hc3, 4'he);
    endtask

    task automatic t_ignore_live();   // R11
        cyc(1, 0, 0, 0, 0, 5'h0c, 8'h81, 4'h5);
        for (int i = 0; i < 6; i++) begin
            cyc(0, 0, 0, 0, 0, 5'(i * 7), 8'(i * 37 + 1), 4'(i + 8));
        end
        cyc(0, 0, 0, 1, 0, 5'h1e, 8'hee, 4'ha);
        cyc(0, 0, 0, 1, 1, 5'h1e, 8'hee, 4'ha);
        check_out("R11", 1, 5'h0c, 8'h81, 4'h5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_capture_lo();
        t_capture_hi();
        t_fast_call();
        t_repeat();
        t_plain_ret();
        t_nested();
        t_same_cycle();
        t_ignore_live();
        idle();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule